// File: doc/BRIEF.md
# Isochronous Receive Admission Filter

This block sits in front of one isochronous receive context and decides, packet by packet, whether the context takes the packet. Admission works in one of two ways. A single-channel context compares each packet's channel number with one configured channel. A multi-channel context looks the channel up in a 64-bit enable mask, where bit n enables channel n.

The block also decides when the context starts receiving. If a cycle-match request is pending, the context waits for a cycleStart event whose 13-bit cycle count equals the configured match value. It then starts and withdraws the pending request. With no request pending, the first packet that passes the channel filter while run is high starts the context, and that packet is admitted.

For each admitted packet the block reports whether the 4-byte isochronous header is to be kept in front of the payload. When the header is kept, the block supplies a trailer word made of the packet's transfer status and the time stamp of the most recent cycleStart.

Top module: `iso_rx_admit`

## Requirements
- R1: While reset is asserted and on the first cycle after it, accept_o, keep_hdr_o, start_o, active_o and cme_o are 0 and trailer_o is all zeros.
- R2: With multi_chan_i low, a packet is accepted only when pkt_chan_i equals own_chan_i.
- R3: With multi_chan_i high, a packet on channel n is accepted exactly when chan_mask_i bit n is 1, and own_chan_i has no effect.
- R4: While cme_o is 1, the context starts only on a cs_valid_i cycle whose cs_cycle_i equals cyc_match_i. Packets and cycleStart events with other counts neither start the context nor are accepted.
- R5: start_o is a pulse one cycle long. It rises together with active_o, and a start caused by a cycle match clears cme_o on that same cycle. cme_set_i sets cme_o on the following cycle.
- R6: A packet that arrives in the same cycle as the matching cycleStart is not accepted. Packets on the cycles after it are accepted.
- R7: With cme_o at 0 and run_i high, the first packet that passes the channel filter starts the context, and that packet is itself accepted. start_o and accept_o are then high together.
- R8: With run_i low, no packet is accepted, and active_o is 0 on the following cycle.
- R9: keep_hdr_o is high exactly when accept_o is high and hdr_keep_i was high. trailer_o is then {pkt_status_i, stamp}, where stamp (the low 16 bits) is cs_stamp_i of the latest cycleStart in a cycle before the packet. Otherwise trailer_o is zero.
- R10: accept_o, keep_hdr_o and trailer_o appear on the cycle after pkt_valid_i, and accept_o is 0 when pkt_valid_i was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Context run enable |
| multi_chan_i | input | 1 | 1 = mask admission, 0 = single channel |
| hdr_keep_i | input | 1 | Keep isochronous header and append trailer |
| cme_set_i | input | 1 | Pulse that arms cycle-match start |
| own_chan_i | input | 6 | Single configured channel |
| chan_mask_i | input | 64 | Channel enable mask, bit n for channel n |
| cyc_match_i | input | 13 | Cycle count the start waits for |
| cs_valid_i | input | 1 | cycleStart event strobe |
| cs_cycle_i | input | 13 | Cycle count carried by the cycleStart |
| cs_stamp_i | input | 16 | Time stamp of the cycleStart |
| pkt_valid_i | input | 1 | Packet strobe |
| pkt_chan_i | input | 6 | Packet channel number |
| pkt_status_i | input | 16 | Packet transfer status |
| accept_o | output | 1 | Packet admitted |
| keep_hdr_o | output | 1 | Admitted packet keeps its header and trailer |
| trailer_o | output | 32 | {status, cycleStart stamp} |
| start_o | output | 1 | Context start pulse |
| active_o | output | 1 | Context running |
| cme_o | output | 1 | Cycle-match start pending |

## Verification
The assertions assume that cme_set_i is pulsed only while run_i and active_o are both low. Arming a match while the context is running is outside the model. The bench raises cme_set_i only after dropping run_i and waiting one cycle for active_o to fall. It also never changes multi_chan_i or hdr_keep_i on the same cycle as a packet strobe, so every packet is judged against settled mode bits.

// File: rtl/iso_rx_admit_pkg.sv
package iso_rx_admit_pkg;

    typedef struct packed {
        logic active;
        logic cme;
        logic start;
        logic accept;
        logic keep_hdr;
    } adm_flags_t;

    localparam adm_flags_t ADM_FLAGS_RST = '{default: 1'b0};

endpackage

// File: rtl/iso_rx_chan_filter.sv
module iso_rx_chan_filter #(
    parameter int CHAN_W = 6
) (
    input  logic                      multi_i,
    input  logic [CHAN_W-1:0]         own_chan_i,
    input  logic [(1<<CHAN_W)-1:0]    mask_i,
    input  logic [CHAN_W-1:0]         chan_i,
    output logic                      hit_o
);
    localparam int NCH = 1 << CHAN_W;

    logic [NCH-1:0] chan_sel;
    logic           mask_hit;
    logic           own_hit;

    for (genvar n = 0; n < NCH; n++) begin : g_dec
        assign chan_sel[n] = (chan_i == CHAN_W'(n)) && mask_i[n];
    end

    assign mask_hit = |chan_sel;
    assign own_hit  = (chan_i == own_chan_i);
    assign hit_o    = multi_i ? mask_hit : own_hit;
endmodule

// File: rtl/iso_rx_start_gate.sv
module iso_rx_start_gate #(
    parameter int CYC_W = 13
) (
    input  logic             run_i,
    input  logic             active_i,
    input  logic             cme_i,
    input  logic             cs_valid_i,
    input  logic [CYC_W-1:0] cs_cycle_i,
    input  logic [CYC_W-1:0] cyc_match_i,
    input  logic             pkt_valid_i,
    input  logic             chan_hit_i,
    output logic             begin_pkt_o,
    output logic             begin_cs_o
);
    logic idle_run;
    logic cyc_eq;

    assign idle_run    = run_i && !active_i;
    assign cyc_eq      = cs_valid_i && (cs_cycle_i == cyc_match_i);
    assign begin_cs_o  = idle_run && cme_i && cyc_eq;
    assign begin_pkt_o = idle_run && !cme_i && pkt_valid_i && chan_hit_i;
endmodule

// File: rtl/iso_rx_admit.sv
module iso_rx_admit
    import iso_rx_admit_pkg::*;
#(
    parameter int CHAN_W  = 6,
    parameter int CYC_W   = 13,
    parameter int STAT_W  = 16,
    parameter int STAMP_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       run_i,
    input  logic                       multi_chan_i,
    input  logic                       hdr_keep_i,
    input  logic                       cme_set_i,
    input  logic [CHAN_W-1:0]          own_chan_i,
    input  logic [(1<<CHAN_W)-1:0]     chan_mask_i,
    input  logic [CYC_W-1:0]           cyc_match_i,
    input  logic                       cs_valid_i,
    input  logic [CYC_W-1:0]           cs_cycle_i,
    input  logic [STAMP_W-1:0]         cs_stamp_i,
    input  logic                       pkt_valid_i,
    input  logic [CHAN_W-1:0]          pkt_chan_i,
    input  logic [STAT_W-1:0]          pkt_status_i,
    output logic                       accept_o,
    output logic                       keep_hdr_o,
    output logic [STAT_W+STAMP_W-1:0]  trailer_o,
    output logic                       start_o,
    output logic                       active_o,
    output logic                       cme_o
);
    localparam int TRL_W = STAT_W + STAMP_W;

    typedef struct packed {
        adm_flags_t         f;
        logic [STAMP_W-1:0] stamp;
        logic [TRL_W-1:0]   trailer;
    } adm_state_t;

    adm_state_t st_d, st_q;
    logic       chan_hit;
    logic       begin_pkt;
    logic       begin_cs;

    iso_rx_chan_filter #(.CHAN_W(CHAN_W)) i_filter (
        .multi_i    (multi_chan_i),
        .own_chan_i (own_chan_i),
        .mask_i     (chan_mask_i),
        .chan_i     (pkt_chan_i),
        .hit_o      (chan_hit)
    );

    iso_rx_start_gate #(.CYC_W(CYC_W)) i_gate (
        .run_i       (run_i),
        .active_i    (st_q.f.active),
        .cme_i       (st_q.f.cme),
        .cs_valid_i  (cs_valid_i),
        .cs_cycle_i  (cs_cycle_i),
        .cyc_match_i (cyc_match_i),
        .pkt_valid_i (pkt_valid_i),
        .chan_hit_i  (chan_hit),
        .begin_pkt_o (begin_pkt),
        .begin_cs_o  (begin_cs)
    );

    always_comb begin
        logic admit;
        st_d  = st_q;
        admit = run_i && pkt_valid_i && chan_hit && (st_q.f.active || begin_pkt);

        st_d.f.start    = begin_pkt || begin_cs;
        st_d.f.active   = run_i && (st_q.f.active || begin_pkt || begin_cs);
        st_d.f.cme      = (st_q.f.cme || cme_set_i) && !begin_cs;
        st_d.f.accept   = admit;
        st_d.f.keep_hdr = admit && hdr_keep_i;
        st_d.trailer    = (admit && hdr_keep_i) ? {pkt_status_i, st_q.stamp} : '0;
        if (cs_valid_i) begin
            st_d.stamp = cs_stamp_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.f       <= ADM_FLAGS_RST;
            st_q.stamp   <= '0;
            st_q.trailer <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign accept_o   = st_q.f.accept;
    assign keep_hdr_o = st_q.f.keep_hdr;
    assign trailer_o  = st_q.trailer;
    assign start_o    = st_q.f.start;
    assign active_o   = st_q.f.active;
    assign cme_o      = st_q.f.cme;
endmodule

// File: rtl/iso_rx_admit_chk.sv
module iso_rx_admit_chk #(
    parameter int CHAN_W  = 6,
    parameter int CYC_W   = 13,
    parameter int STAT_W  = 16,
    parameter int STAMP_W = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      run_i,
    input logic                      multi_chan_i,
    input logic                      hdr_keep_i,
    input logic [CHAN_W-1:0]         own_chan_i,
    input logic [(1<<CHAN_W)-1:0]    chan_mask_i,
    input logic [CYC_W-1:0]          cyc_match_i,
    input logic                      cs_valid_i,
    input logic [CYC_W-1:0]          cs_cycle_i,
    input logic                      pkt_valid_i,
    input logic [CHAN_W-1:0]         pkt_chan_i,
    input logic                      accept_o,
    input logic                      keep_hdr_o,
    input logic [STAT_W+STAMP_W-1:0] trailer_o,
    input logic                      start_o,
    input logic                      active_o,
    input logic                      cme_o
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> !accept_o && !keep_hdr_o && !start_o && !active_o && !cme_o && trailer_o == '0);

    // R2
    single_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o && !$past(multi_chan_i) |-> $past(pkt_chan_i) == $past(own_chan_i));

    // R3
    mask_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o && $past(multi_chan_i) |-> $past(chan_mask_i[pkt_chan_i]));

    // R4
    match_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o && $past(cme_o) |-> $past(cs_valid_i) && $past(cs_cycle_i) == $past(cyc_match_i));

    // R5
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

    // R5
    active_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_o) |-> start_o);

    // R5
    cme_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o && $past(cme_o) |-> !cme_o);

    // R6
    same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o && $past(cme_o) |-> !accept_o);

    // R8
    run_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run_i) |-> !active_o && !accept_o);

    // R9
    keep_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        keep_hdr_o |-> accept_o && $past(hdr_keep_i));

    // R10
    no_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pkt_valid_i) |-> !accept_o);
endmodule

bind iso_rx_admit iso_rx_admit_chk #(
    .CHAN_W(CHAN_W), .CYC_W(CYC_W), .STAT_W(STAT_W), .STAMP_W(STAMP_W)
) i_admit_chk (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .multi_chan_i(multi_chan_i),
    .hdr_keep_i(hdr_keep_i), .own_chan_i(own_chan_i), .chan_mask_i(chan_mask_i),
    .cyc_match_i(cyc_match_i), .cs_valid_i(cs_valid_i), .cs_cycle_i(cs_cycle_i),
    .pkt_valid_i(pkt_valid_i), .pkt_chan_i(pkt_chan_i), .accept_o(accept_o),
    .keep_hdr_o(keep_hdr_o), .trailer_o(trailer_o), .start_o(start_o),
    .active_o(active_o), .cme_o(cme_o)
);

// File: tb/test_iso_rx_admit.sv
module test_iso_rx_admit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_i = 0, multi_chan_i = 0, hdr_keep_i = 0, cme_set_i = 0;
    logic [5:0]  own_chan_i = '0;
    logic [63:0] chan_mask_i = '0;
    logic [12:0] cyc_match_i = '0;
    logic        cs_valid_i = 0;
    logic [12:0] cs_cycle_i = '0;
    logic [15:0] cs_stamp_i = '0;
    logic        pkt_valid_i = 0;
    logic [5:0]  pkt_chan_i = '0;
    logic [15:0] pkt_status_i = '0;
    logic        accept_o, keep_hdr_o, start_o, active_o, cme_o;
    logic [31:0] trailer_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    iso_rx_admit i_iso_rx_admit (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .multi_chan_i(multi_chan_i),
        .hdr_keep_i(hdr_keep_i), .cme_set_i(cme_set_i), .own_chan_i(own_chan_i),
        .chan_mask_i(chan_mask_i), .cyc_match_i(cyc_match_i), .cs_valid_i(cs_valid_i),
        .cs_cycle_i(cs_cycle_i), .cs_stamp_i(cs_stamp_i), .pkt_valid_i(pkt_valid_i),
        .pkt_chan_i(pkt_chan_i), .pkt_status_i(pkt_status_i), .accept_o(accept_o),
        .keep_hdr_o(keep_hdr_o), .trailer_o(trailer_o), .start_o(start_o),
        .active_o(active_o), .cme_o(cme_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pkt(input logic [5:0] ch, input logic [15:0] st);
        pkt_valid_i = 1; pkt_chan_i = ch; pkt_status_i = st;
        @(negedge clk);
        pkt_valid_i = 0;
    endtask

    task automatic cstart(input logic [12:0] cyc, input logic [15:0] ts);
        cs_valid_i = 1; cs_cycle_i = cyc; cs_stamp_i = ts;
        @(negedge clk);
        cs_valid_i = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] m;
        logic [12:0] mt;
        repeat (3) @(negedge clk);
        chk("R1 reset flags", {accept_o, keep_hdr_o, start_o, active_o, cme_o}, 0);
        chk("R1 reset trailer", trailer_o, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 after reset", {accept_o, start_o, active_o, cme_o}, 0);

        // R8: run low, matching packet refused
        own_chan_i = 6'd5;
        pkt(6'd5, 16'h0001);
        chk("R8 run low accept", accept_o, 0);
        chk("R8 run low active", active_o, 0);

        // R7: first filtered packet starts and is admitted
        run_i = 1;
        @(negedge clk);
        pkt(6'd7, 16'h0002);
        chk("R7 no start on other channel", {start_o, accept_o}, 0);
        pkt(6'd5, 16'h0003);
        chk("R7 start with packet", {start_o, accept_o, active_o}, 3'b111);
        @(negedge clk);
        chk("R5 start pulse ends", start_o, 0);
        chk("R10 idle no accept", accept_o, 0);

        // R2 sweep
        foreach (own_chan_i[b]) begin end
        for (int k = 0; k < 3; k++) begin
            own_chan_i = (k == 0) ? 6'd0 : (k == 1) ? 6'd37 : 6'd63;
            for (int c = 0; c < 64; c++) begin
                pkt(6'(c), 16'h0);
                chk("R2 single channel", accept_o, 64'(6'(c) == own_chan_i));
                chk("R9 no header keep", {keep_hdr_o, trailer_o}, 0);
            end
        end

        // R3 sweep with two masks
        multi_chan_i = 1;
        for (int k = 0; k < 2; k++) begin
            m = (k == 0) ? 64'hA5C3_0F1E_9B27_6D48 : ~64'hA5C3_0F1E_9B27_6D48;
            chan_mask_i = m;
            own_chan_i = (k == 0) ? 6'd0 : 6'd3;
            @(negedge clk);
            for (int c = 0; c < 64; c++) begin
                pkt(6'(c), 16'h0);
                chk("R3 mask channel", accept_o, 64'(m[c]));
            end
        end
        multi_chan_i = 0;

        // R9 header and trailer
        hdr_keep_i = 1; own_chan_i = 6'd9;
        @(negedge clk);
        cstart(13'd100, 16'h1234);
        pkt(6'd9, 16'hBEEF);
        chk("R9 keep header", {accept_o, keep_hdr_o}, 2'b11);
        chk("R9 trailer", trailer_o, 32'hBEEF_1234);
        pkt(6'd10, 16'hBEEF);
        chk("R9 refused no trailer", {accept_o, keep_hdr_o, trailer_o}, 0);
        cstart(13'd101, 16'h0042);
        cstart(13'd102, 16'h0077);
        pkt(6'd9, 16'h5A5A);
        chk("R9 latest stamp", trailer_o, 32'h5A5A_0077);

        // R8 run drop
        run_i = 0;
        @(negedge clk);
        chk("R8 active falls", active_o, 0);
        pkt(6'd9, 16'h0);
        chk("R8 refused", accept_o, 0);

        // R4/R5/R6 cycle match start
        mt = 13'h1ABC; cyc_match_i = mt;
        cme_set_i = 1;
        @(negedge clk);
        cme_set_i = 0;
        chk("R5 cme set", cme_o, 1);
        run_i = 1;
        @(negedge clk);
        pkt(6'd9, 16'h0);
        chk("R4 packet before match", {accept_o, start_o, active_o}, 0);
        for (int k = 0; k < 4; k++) begin
            cstart((k == 0) ? mt ^ 13'd1 : (k == 1) ? mt ^ 13'h1000 :
                   (k == 2) ? mt + 13'd1 : mt - 13'd1, 16'h0);
            chk("R4 wrong cycle", {start_o, active_o, cme_o}, 3'b001);
        end
        pkt_valid_i = 1; pkt_chan_i = 6'd9; pkt_status_i = 16'h1111;
        cs_valid_i = 1; cs_cycle_i = mt; cs_stamp_i = 16'h5555;
        @(negedge clk);
        pkt_valid_i = 0; cs_valid_i = 0;
        chk("R4 start on match", {start_o, active_o}, 2'b11);
        chk("R5 cme cleared", cme_o, 0);
        chk("R6 same cycle refused", accept_o, 0);
        pkt(6'd9, 16'h2222);
        chk("R6 next accepted", {accept_o, keep_hdr_o, start_o}, 3'b110);
        chk("R6 trailer stamp", trailer_o, 32'h2222_5555);
        cstart(mt, 16'h6666);
        chk("R5 no restart", start_o, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule